// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Counter

This peripheral supervises software by counting down towards a forced reset. It holds two down-counters behind a small 32-bit register bus: the main watchdog counter and a warning counter that software loads with a shorter interval, so that a warning interrupt comes before the final expiry. Each counter advances on a tick. The tick comes either from a shared prescaler that divides the core clock by a programmable power of two, or from an external fixed-rate reference tick pulse.

Software keeps the system alive by rewriting the counters with fresh values while they keep running. If the main counter reaches zero, a sticky expiry flag is set and the timeout interrupt goes high. A single-cycle reset request is also issued, but only when the reset-output enable is set, the reset mask is clear and the watchdog is enabled. The warning counter sets its own sticky flag and drives its own interrupt. Software clears each flag by writing a zero to its bit.

The bus is a single-cycle interface. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. `bus_rdata` is combinational from `bus_addr` whenever `bus_sel` is high and `bus_wr` is low, and reads as zero otherwise.

Top module: `wdog_pretimeout`

## Requirements
- R1: After reset, the control register (0x00) reads 0, the status register (0x04) reads 0, both count registers (0x08 watchdog, 0x0C warning) read 0xFFFFFFFF, the reset-output enable register (0x10, bit 0) reads 0, the mask register (0x14, bit 0) reads 1, and all three outputs are low. Unmapped addresses read 0.
- R2: When control bit 0 is set, the watchdog counter decreases by exactly one on each tick of its selected source. When that bit is clear, the counter holds its value.
- R3: The prescaled tick occurs once every 2^N core clock cycles, where N is control field [12:8]. N = 0 gives a tick on every cycle. The prescaler runs freely from reset.
- R4: Control bit 2 makes the watchdog counter use `ref_tick` in place of the prescaled tick. Control bit 3 does the same for the warning counter.
- R5: The warning counter is enabled by control bit 1. It counts in the same way as the watchdog counter, independently of it.
- R6: A counter that steps from 1 to 0 stays at 0 until it is reloaded. That step sets its sticky status bit: bit 0 for the watchdog and bit 1 for the warning counter.
- R7: A status bit is cleared by writing 0 to it at 0x04. Writing 1 to it leaves it unchanged. An event in the same cycle as a clear wins, so the bit stays set.
- R8: `irq_timeout` equals status bit 0 and `irq_pretimeout` equals status bit 1.
- R9: Writing a count register loads it at that clock edge; the load takes priority over a tick in the same cycle. A read returns the remaining count.
- R10: `rst_req` is high for exactly one cycle, in the cycle after the watchdog counter steps to 0. It is issued only if, in that stepping cycle, the reset-output enable bit is 1, the mask bit is 0 and control bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Fixed-rate reference tick, one cycle per tick |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_timeout | output | 1 | Level interrupt on watchdog expiry |
| irq_pretimeout | output | 1 | Level interrupt on warning-counter expiry |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The properties assume that a count register changes only through a bus write or through its own step. They also assume that a set expiry flag can fall only in a cycle that writes a zero to it. Both assumptions hold for any bus traffic, so the random stimulus writes freely to all registers. That traffic includes mask and enable toggles close to expiry and status clears that coincide with events. The random count loads are kept small, and the prescaler ratios are kept low, so that counters actually reach zero within the run. Directed sequences cover each reset-output gating condition one at a time.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int RATIO_W = 5;
    localparam int NCH     = 2;   // index 0: watchdog, index 1: warning

    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h04;
    localparam logic [ADDR_W-1:0] A_WDCNT  = 8'h08;
    localparam logic [ADDR_W-1:0] A_PRECNT = 8'h0C;
    localparam logic [ADDR_W-1:0] A_RSTEN  = 8'h10;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h14;

    localparam int RATIO_LSB = 8;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               pre_fixed;
        logic               wd_fixed;
        logic               pre_en;
        logic               wd_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(logic [BUS_W-1:0] w);
        ctrl_t c;
        c.wd_en     = w[0];
        c.pre_en    = w[1];
        c.wd_fixed  = w[2];
        c.pre_fixed = w[3];
        c.ratio     = w[RATIO_LSB +: RATIO_W];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_to_word(ctrl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[0] = c.wd_en;
        w[1] = c.pre_en;
        w[2] = c.wd_fixed;
        w[3] = c.pre_fixed;
        w[RATIO_LSB +: RATIO_W] = c.ratio;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] count_addr(int ch);
        return (ch == 0) ? A_WDCNT : A_PRECNT;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    localparam int PW = 2 ** RATIO_W;

    logic [PW-1:0] free_cnt;
    logic [PW-1:0] low_mask;

    always_comb begin
        low_mask = (PW'(1) << ratio) - PW'(1);
        tick     = ((free_cnt & low_mask) == low_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) free_cnt <= '0;
        else     free_cnt <= free_cnt + PW'(1);
    end
endmodule

// File: rtl/wdog_downcounter.sv
module wdog_downcounter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         hit
);
    logic step;

    always_comb begin
        step = en && tick && !load && (count != '0);
        hit  = step && (count == W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)       count <= '1;
        else if (load) count <= load_val;
        else if (step) count <= count - W'(1);
    end
endmodule

// File: rtl/wdog_pretimeout.sv
module wdog_pretimeout
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_timeout,
    output logic              irq_pretimeout,
    output logic              rst_req
);
    ctrl_t              ctrl_q;
    logic [NCH-1:0]     stat_q;
    logic               rst_en_q;
    logic               mask_q;
    logic               rst_req_q;
    logic               ptick;
    logic               wr;

    logic [CNT_W-1:0]   cnt   [NCH];
    logic [NCH-1:0]     ch_en;
    logic [NCH-1:0]     ch_fixed;
    logic [NCH-1:0]     ch_tick;
    logic [NCH-1:0]     ch_load;
    logic [NCH-1:0]     ch_hit;

    assign wr = bus_sel && bus_wr;

    wdog_prescaler u_presc (
        .clk   (clk),
        .rst   (rst),
        .ratio (ctrl_q.ratio),
        .tick  (ptick)
    );

    assign ch_en    = {ctrl_q.pre_en, ctrl_q.wd_en};
    assign ch_fixed = {ctrl_q.pre_fixed, ctrl_q.wd_fixed};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_tick[g] = ch_fixed[g] ? ref_tick : ptick;
        assign ch_load[g] = wr && (bus_addr == count_addr(g));

        wdog_downcounter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .en       (ch_en[g]),
            .tick     (ch_tick[g]),
            .load     (ch_load[g]),
            .load_val (bus_wdata[CNT_W-1:0]),
            .count    (cnt[g]),
            .hit      (ch_hit[g])
        );

        // sticky flag: event beats a same-cycle clear
        always_ff @(posedge clk) begin
            if (rst)
                stat_q[g] <= 1'b0;
            else if (ch_hit[g])
                stat_q[g] <= 1'b1;
            else if (wr && bus_addr == A_STAT && !bus_wdata[g])
                stat_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            rst_en_q  <= 1'b0;
            mask_q    <= 1'b1;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= ch_hit[0] && rst_en_q && !mask_q && ctrl_q.wd_en;
            if (wr && bus_addr == A_CTRL)  ctrl_q   <= ctrl_from_word(bus_wdata);
            if (wr && bus_addr == A_RSTEN) rst_en_q <= bus_wdata[0];
            if (wr && bus_addr == A_MASK)  mask_q   <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                A_CTRL:   bus_rdata = ctrl_to_word(ctrl_q);
                A_STAT:   bus_rdata = BUS_W'(stat_q);
                A_WDCNT:  bus_rdata = BUS_W'(cnt[0]);
                A_PRECNT: bus_rdata = BUS_W'(cnt[1]);
                A_RSTEN:  bus_rdata = BUS_W'(rst_en_q);
                A_MASK:   bus_rdata = BUS_W'(mask_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq_timeout    = stat_q[0];
    assign irq_pretimeout = stat_q[1];
    assign rst_req        = rst_req_q;

endmodule

// File: rtl/wdog_pretimeout_chk.sv
module wdog_pretimeout_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              stat_wbit0,
    input logic [CNT_W-1:0]  load_val,
    input logic              wd_load,
    input logic              pre_load,
    input logic              wd_en,
    input logic [CNT_W-1:0]  wd_cnt,
    input logic [CNT_W-1:0]  pre_cnt,
    input logic              rst_en,
    input logic              mask,
    input logic              irq_timeout,
    input logic              rst_req
);
    logic clr0;
    assign clr0 = bus_sel && bus_wr && (bus_addr == A_STAT) && !stat_wbit0;

    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (!wd_load && wd_cnt != '0) |=>
            (wd_cnt == $past(wd_cnt) || wd_cnt == $past(wd_cnt) - CNT_W'(1)));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!wd_en && !wd_load) |=> $stable(wd_cnt));

    a_r6_wd_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (!wd_load && wd_cnt == '0) |=> (wd_cnt == '0));

    a_r6_pre_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (!pre_load && pre_cnt == '0) |=> (pre_cnt == '0));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_timeout && !clr0) |=> irq_timeout);

    a_r9_load_value: assert property (@(posedge clk) disable iff (rst)
        wd_load |=> (wd_cnt == $past(load_val)));

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    a_r10_gated: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(wd_en && rst_en && !mask));

endmodule

bind wdog_pretimeout wdog_pretimeout_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .stat_wbit0  (bus_wdata[0]),
    .load_val    (bus_wdata[CNT_W-1:0]),
    .wd_load     (ch_load[0]),
    .pre_load    (ch_load[1]),
    .wd_en       (ctrl_q.wd_en),
    .wd_cnt      (cnt[0]),
    .pre_cnt     (cnt[1]),
    .rst_en      (rst_en_q),
    .mask        (mask_q),
    .irq_timeout (irq_timeout),
    .rst_req     (rst_req)
);

// File: tb/wdog_pretimeout_bench.sv
module wdog_pretimeout_bench;
    import wdog_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_timeout, irq_pretimeout, rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit rand_ref = 0;
    int pulses = 0;

    always #4 clk = ~clk;

    wdog_pretimeout u_wdog_pretimeout (
        .clk(clk), .rst(rst), .ref_tick(ref_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_timeout(irq_timeout), .irq_pretimeout(irq_pretimeout),
        .rst_req(rst_req)
    );

    // reference model, updated from the requirements at each clock edge
    logic [31:0] m_cnt [2];
    logic [1:0]  m_stat;
    logic [31:0] m_ctrl;
    logic        m_rsten, m_mask, m_rreq;
    logic [31:0] m_k;

    function automatic logic model_tick(logic [31:0] k, logic [4:0] n);
        logic [31:0] period;
        period = 32'd1 << n;
        return (k % period) == period - 32'd1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt[0] = '1; m_cnt[1] = '1; m_stat = '0; m_ctrl = '0;
            m_rsten = 0; m_mask = 1; m_rreq = 0; m_k = '0;
        end else begin
            logic pt;
            logic [1:0] hit;
            logic w;
            w   = bus_sel && bus_wr;
            pt  = model_tick(m_k, m_ctrl[12:8]);
            m_k = m_k + 1;
            hit = '0;
            for (int ch = 0; ch < 2; ch++) begin
                logic tk;
                tk = m_ctrl[2 + ch] ? ref_tick : pt;
                if (w && bus_addr == (ch == 0 ? 8'h08 : 8'h0C))
                    m_cnt[ch] = bus_wdata;
                else if (m_ctrl[ch] && tk && m_cnt[ch] != 0) begin
                    m_cnt[ch] = m_cnt[ch] - 1;
                    if (m_cnt[ch] == 0) hit[ch] = 1;
                end
            end
            m_rreq = hit[0] && m_rsten && !m_mask && m_ctrl[0];
            for (int b = 0; b < 2; b++) begin
                if (hit[b]) m_stat[b] = 1;
                else if (w && bus_addr == 8'h04 && !bus_wdata[b]) m_stat[b] = 0;
            end
            if (w && bus_addr == 8'h00) m_ctrl = bus_wdata & 32'h0000_1F0F;
            if (w && bus_addr == 8'h10) m_rsten = bus_wdata[0];
            if (w && bus_addr == 8'h14) m_mask = bus_wdata[0];
        end
    end

    function automatic logic [31:0] model_read(logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h04: return {30'd0, m_stat};
            8'h08: return m_cnt[0];
            8'h0C: return m_cnt[1];
            8'h10: return {31'd0, m_rsten};
            8'h14: return {31'd0, m_mask};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle output comparison (R8 interrupts, R10 reset pulse)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R8 irq_timeout",    {31'd0, irq_timeout},    {31'd0, m_stat[0]});
            check("R8 irq_pretimeout", {31'd0, irq_pretimeout}, {31'd0, m_stat[1]});
            check("R10 rst_req",       {31'd0, rst_req},        {31'd0, m_rreq});
            if (rst_req) pulses++;
        end
    end

    always @(negedge clk) begin
        if (rand_ref) ref_tick <= ($urandom % 3) == 0;
    end

    task automatic wr_reg(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_chk(logic [7:0] a, string req);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        check(req, bus_rdata, model_read(a));
        bus_sel = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h04: return "R7";
            8'h08: return "R9";
            8'h0C: return "R5";
            default: return "R1";
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        check("R1 irq_timeout", {31'd0, irq_timeout}, 32'd0);
        check("R1 rst_req", {31'd0, rst_req}, 32'd0);
        rd_chk(8'h00, "R1 ctrl");
        rd_chk(8'h04, "R1 status");
        rd_chk(8'h08, "R1 wd count");
        rd_chk(8'h0C, "R1 pre count");
        rd_chk(8'h10, "R1 rsten");
        rd_chk(8'h14, "R1 mask");
        rd_chk(8'h20, "R1 unmapped");
        check("R1 mask value", model_read(8'h14), 32'd1);

        // R2: disabled counter holds
        wr_reg(8'h08, 32'd40);
        idle(10);
        rd_chk(8'h08, "R2 hold when disabled");

        // R3: prescaler ratio 2 (tick every 4 cycles)
        wr_reg(8'h00, 32'h0000_0201);
        idle(13);
        rd_chk(8'h08, "R3 ratio 2 count");
        wr_reg(8'h00, 32'h0000_0001);
        idle(5);
        rd_chk(8'h08, "R2 ratio 0 count");

        // R4: fixed reference tick
        wr_reg(8'h08, 32'd30);
        wr_reg(8'h00, 32'h0000_0005);
        rand_ref = 1;
        idle(20);
        rd_chk(8'h08, "R4 ref tick count");
        rand_ref = 0;
        @(negedge clk) ref_tick = 0;

        // R5/R6: warning counter expiry, hold at zero
        wr_reg(8'h00, 32'h0000_0000);
        wr_reg(8'h0C, 32'd6);
        wr_reg(8'h00, 32'h0000_0002);
        idle(12);
        rd_chk(8'h0C, "R6 pre count held at zero");
        rd_chk(8'h04, "R6 pre flag set");
        check("R8 irq_pretimeout high", {31'd0, irq_pretimeout}, 32'd1);

        // R7: write 1 keeps, write 0 clears
        wr_reg(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, "R7 write one keeps");
        wr_reg(8'h04, 32'h0);
        rd_chk(8'h04, "R7 write zero clears");

        // R10: gating conditions
        wr_reg(8'h10, 32'd1);
        wr_reg(8'h14, 32'd0);
        pulses = 0;
        wr_reg(8'h08, 32'd5);
        wr_reg(8'h00, 32'h0000_0001);
        idle(12);
        check("R10 one pulse when ungated", pulses, 32'd1);
        rd_chk(8'h04, "R6 wd flag set");
        wr_reg(8'h14, 32'd1);
        pulses = 0;
        wr_reg(8'h08, 32'd4);
        idle(10);
        check("R10 no pulse when masked", pulses, 32'd0);
        wr_reg(8'h14, 32'd0);
        wr_reg(8'h10, 32'd0);
        pulses = 0;
        wr_reg(8'h08, 32'd4);
        idle(10);
        check("R10 no pulse when output disabled", pulses, 32'd0);

        // R9: pings keep the counter away from zero
        wr_reg(8'h04, 32'h0);
        wr_reg(8'h10, 32'd1);
        pulses = 0;
        for (int i = 0; i < 5; i++) begin
            wr_reg(8'h08, 32'd8);
            rd_chk(8'h08, "R9 reload value");
            idle(3);
        end
        check("R9 no expiry while pinged", {31'd0, irq_timeout}, 32'd0);
        check("R9 no pulse while pinged", pulses, 32'd0);

        // random traffic
        rand_ref = 1;
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] a;
            op = $urandom % 8;
            case (op)
                0: wr_reg(8'h00, {19'd0, 5'($urandom % 4), 4'd0, 4'($urandom)});
                1: wr_reg(8'h08, $urandom % 48);
                2: wr_reg(8'h0C, $urandom % 48);
                3: wr_reg(8'h04, $urandom);
                4: wr_reg(8'h10, $urandom % 2);
                5: wr_reg(8'h14, ($urandom % 4) == 0);
                default: begin
                    a = 8'(($urandom % 7) * 4);
                    rd_chk(a, tag_of(a));
                end
            endcase
            idle($urandom % 8);
        end
        rand_ref = 0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired, run hung");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule